// File: doc/BRIEF.md
# Pipelined Barrel Right Shifter

This block shifts a 32-bit word to the right by a 5-bit distance. It has two modes. In logical mode the vacated upper bits take zeros. In arithmetic mode they take copies of the word's sign bit. The work is split over an elastic pipeline with one stage per shift-distance bit. Stage k moves the word right by 2^k positions when bit k of the distance is set, and passes it through unchanged when the bit is clear. Each stage's choice between the two is made by a 2:1 selector built from AND, OR and NOT gates.

A producer offers a request (mode, word, distance) on a valid/ready pair. A consumer takes results from a second valid/ready pair. Every slot of the pipeline has its own valid flag. Ready travels back through the slots, so a stalled consumer holds the upstream stages, and a gap anywhere in the pipeline lets the producer continue. While the consumer does not stall, one request enters and one result leaves every clock cycle.

Top module: `rshift_pipe`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With in_mode = 0 (logical), the result is in_data shifted right by in_shamt, with zeros in the vacated upper bits.
- R3: With in_mode = 1 (arithmetic), the vacated upper bits are filled with bit 31 of in_data; the other bits are as in R2.
- R4: A distance of 0 returns in_data unchanged in both modes.
- R5: A distance of 31 yields 0 or 1 in logical mode, and 32 copies of bit 31 in arithmetic mode.
- R6: In an empty pipeline with out_ready held at 1, a request accepted at clock edge E raises out_valid after edge E+5.
- R7: While out_ready is 1, in_ready is 1. A request can be accepted and a result delivered on every cycle.
- R8: Results leave in exactly the order in which their requests were accepted.
- R9: While out_valid is 1 and out_ready is 0, out_valid and out_data hold. The pipeline holds at most six requests. With six requests held and out_ready at 0, in_ready is 0. With fewer than six held, in_ready is 1.
- R10: Each accepted request produces exactly one result. No result appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The pipeline can accept the offered request |
| in_mode | input | 1 | 0 = logical fill, 1 = arithmetic fill |
| in_data | input | 32 | Word to be shifted |
| in_shamt | input | 5 | Shift distance, 0 to 31 |
| out_valid | output | 1 | A result is available |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 32 | Shifted word |

## Verification
The shift function is tried with an all-ones word, a lone top bit, alternating patterns and mixed-sign words, at single-bit distances and at combined distances. This tells apart a stage that ignores its distance bit, a stage that moves by the wrong amount, and a fill that uses the wrong source. Distances 0 and 31 probe the two ends, where a fill error either vanishes or covers the whole word. The handshake is tried three ways: a steady stream with the consumer always ready, which shows the one-per-cycle rate and the six-edge latency; a consumer that stops until every slot is full, which shows that in_ready falls and the output holds; and a consumer stalled on a pseudo-random pattern, which shows that nothing is lost, duplicated or reordered.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

   typedef enum logic {
      MODE_LOGICAL = 1'b0,
      MODE_ARITH   = 1'b1
   } shift_mode_e;

   function automatic logic gate_and(input logic x, input logic y);
      return x & y;
   endfunction

   function automatic logic gate_or(input logic x, input logic y);
      return x | y;
   endfunction

   function automatic logic gate_not(input logic x);
      return ~x;
   endfunction

endpackage

// File: rtl/rshift_gate_mux.sv
module rshift_gate_mux #(
   parameter int W          = 32,
   parameter bit GATE_LEVEL = 1'b1
) (
   input  logic         sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   import rshift_pkg::*;

   if (W < 1) begin : g_bad_width
      $error("rshift_gate_mux: W must be at least 1");
   end

   if (GATE_LEVEL) begin : g_gates
      // y = (sel & b) | (~sel & a), one bit at a time
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign y[i] = gate_or(gate_and(sel, b[i]),
                               gate_and(gate_not(sel), a[i]));
      end
   end else begin : g_behav
      assign y = sel ? b : a;
   end

endmodule

// File: rtl/rshift_stage.sv
module rshift_stage #(
   parameter int W          = 32,
   parameter int DIST       = 1,
   parameter bit GATE_LEVEL = 1'b1
) (
   input  logic         mode_arith,
   input  logic         sel,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   import rshift_pkg::*;

   if (DIST < 1 || DIST >= W) begin : g_bad_dist
      $error("rshift_stage: DIST must lie in 1..W-1");
   end

   logic         fill;
   logic [W-1:0] moved;

   assign fill = gate_and(mode_arith, d_in[W-1]);

   for (genvar j = 0; j < W; j++) begin : g_move
      if (j + DIST < W) begin : g_src
         assign moved[j] = d_in[j+DIST];
      end else begin : g_fill
         assign moved[j] = fill;
      end
   end

   rshift_gate_mux #(
      .W          (W),
      .GATE_LEVEL (GATE_LEVEL)
   ) u_mux (
      .sel (sel),
      .a   (d_in),
      .b   (moved),
      .y   (d_out)
   );

endmodule

// File: rtl/rshift_slot.sv
module rshift_slot #(
   parameter int PAY_W = 38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic [PAY_W-1:0] up_data,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [PAY_W-1:0] dn_data
);

   if (PAY_W < 1) begin : g_bad_width
      $error("rshift_slot: PAY_W must be at least 1");
   end

   logic             vld_q;
   logic [PAY_W-1:0] pay_q;

   assign up_ready = !vld_q || dn_ready;
   assign dn_valid = vld_q;
   assign dn_data  = pay_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else if (up_ready) begin
         vld_q <= up_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (up_valid && up_ready) begin
         pay_q <= up_data;
      end
   end

endmodule

// File: rtl/rshift_pipe.sv
module rshift_pipe #(
   parameter int DATA_W     = 32,
   parameter bit GATE_LEVEL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic                      in_mode,
   input  logic [DATA_W-1:0]         in_data,
   input  logic [$clog2(DATA_W)-1:0] in_shamt,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [DATA_W-1:0]         out_data
);
   import rshift_pkg::*;

   localparam int SHAMT_W = $clog2(DATA_W);
   localparam int STAGES  = SHAMT_W;
   localparam int NSLOT   = STAGES + 1;
   localparam int PAY_W   = 1 + SHAMT_W + DATA_W;
   localparam int MODE_B  = PAY_W - 1;
   localparam int SHM_LO  = DATA_W;

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("rshift_pipe: DATA_W must be a power of two, at least 2");
   end

   logic [PAY_W-1:0] slot_d [NSLOT];
   logic [PAY_W-1:0] slot_q [NSLOT];
   logic             slot_v [NSLOT];
   logic             slot_r [NSLOT];
   logic             slot_in_v [NSLOT];
   logic             slot_dn_r [NSLOT];

   assign slot_d[0]    = {in_mode, in_shamt, in_data};
   assign slot_in_v[0] = in_valid;
   assign in_ready     = slot_r[0];

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      if (k == NSLOT - 1) begin : g_last
         assign slot_dn_r[k] = out_ready;
      end else begin : g_mid
         assign slot_dn_r[k] = slot_r[k+1];
      end

      rshift_slot #(
         .PAY_W (PAY_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .up_valid (slot_in_v[k]),
         .up_ready (slot_r[k]),
         .up_data  (slot_d[k]),
         .dn_valid (slot_v[k]),
         .dn_ready (slot_dn_r[k]),
         .dn_data  (slot_q[k])
      );
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic                mode_s;
      logic [SHAMT_W-1:0]  shamt_s;
      logic [DATA_W-1:0]   word_s;
      logic [DATA_W-1:0]   word_n;

      assign mode_s  = slot_q[s][MODE_B];
      assign shamt_s = slot_q[s][SHM_LO +: SHAMT_W];
      assign word_s  = slot_q[s][DATA_W-1:0];

      rshift_stage #(
         .W          (DATA_W),
         .DIST       (1 << s),
         .GATE_LEVEL (GATE_LEVEL)
      ) u_stage (
         .mode_arith (mode_s == MODE_ARITH),
         .sel        (shamt_s[s]),
         .d_in       (word_s),
         .d_out      (word_n)
      );

      assign slot_d[s+1]    = {mode_s, shamt_s, word_n};
      assign slot_in_v[s+1] = slot_v[s];
   end

   logic unused_tail;
   assign unused_tail = ^slot_q[NSLOT-1][PAY_W-1:DATA_W];

   assign out_valid = slot_v[NSLOT-1];
   assign out_data  = slot_q[NSLOT-1][DATA_W-1:0];

endmodule

// File: rtl/rshift_pipe_chk.sv
module rshift_pipe_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);

   logic [7:0] occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= '0;
      end else begin
         occ <= occ + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_gap_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (occ < 8'(DEPTH)) |-> in_ready);

   assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 8'(DEPTH) && !out_ready) |-> !in_ready);

   assert_stream_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

   assert_no_phantom_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (occ != 8'd0));

   assert_occ_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 8'(DEPTH));

endmodule

bind rshift_pipe rshift_pipe_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (NSLOT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/rshift_pipe_bench.sv
module rshift_pipe_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_mode = 1'b0;
   logic [31:0] in_data = '0;
   logic [4:0]  in_shamt = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;

   int n_tests = 0;
   int n_fail  = 0;
   int n_out   = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   string       cur_tag = "R2";

   always #5 clk = ~clk;

   rshift_pipe u_rshift_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_mode   (in_mode),
      .in_data   (in_data),
      .in_shamt  (in_shamt),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   function automatic logic [31:0] ref_shift(input logic m, input logic [31:0] d,
                                             input logic [4:0] s);
      if (m) return $unsigned($signed(d) >>> s);
      return d >> s;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // monitor: samples 1 ns before each rising edge
   always @(negedge clk) begin
      #4;
      if (rst_n) begin
         if (in_valid && in_ready) begin
            exp_q.push_back(ref_shift(in_mode, in_data, in_shamt));
            tag_q.push_back(cur_tag);
         end
         if (out_valid && out_ready) begin
            n_out++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 output without request", out_data, '0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_data == e, {t, "/R8 result"}, out_data, e);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      check(1'b0, "watchdog expired", '0, '0);
      finish_up();
   end

   // called at a falling edge; returns at a falling edge after acceptance
   task automatic send(input logic m, input logic [31:0] d, input logic [4:0] s,
                       output int waits);
      waits = 0;
      in_valid = 1'b1;
      in_mode  = m;
      in_data  = d;
      in_shamt = s;
      forever begin
         #4;
         if (in_ready) begin
            @(negedge clk);
            break;
         end
         waits++;
         @(negedge clk);
      end
   endtask

   task automatic idle();
      in_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      out_ready = 1'b1;
      idle();
      for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
      check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
   endtask

   task automatic t_reset();
      #4;
      check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
      check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
      @(negedge clk);
   endtask

   task automatic t_logical();
      int w;
      logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h8000_0000, 32'hA5A5_A5A5, 32'h1234_5678};
      cur_tag = "R2";
      foreach (pats[p]) begin
         for (int s = 1; s < 32; s = s * 2 + 1) send(1'b0, pats[p], 5'(s), w);
         send(1'b0, pats[p], 5'd1, w);
         send(1'b0, pats[p], 5'd16, w);
         send(1'b0, pats[p], 5'd10, w);
      end
      drain("R2 drained");
   endtask

   task automatic t_arith();
      int w;
      logic [31:0] pats [4] = '{32'h8000_0000, 32'hF0F0_0F0F, 32'h7FFF_FFFF, 32'hC000_0001};
      cur_tag = "R3";
      foreach (pats[p]) begin
         send(1'b1, pats[p], 5'd1, w);
         send(1'b1, pats[p], 5'd4, w);
         send(1'b1, pats[p], 5'd8, w);
         send(1'b1, pats[p], 5'd21, w);
      end
      drain("R3 drained");
   endtask

   task automatic t_zero();
      int w;
      cur_tag = "R4";
      send(1'b0, 32'h8765_4321, 5'd0, w);
      send(1'b1, 32'h8765_4321, 5'd0, w);
      send(1'b1, 32'h0000_0001, 5'd0, w);
      drain("R4 drained");
   endtask

   task automatic t_max();
      int w;
      cur_tag = "R5";
      send(1'b0, 32'h8000_0000, 5'd31, w);
      send(1'b0, 32'h7FFF_FFFF, 5'd31, w);
      send(1'b1, 32'h8000_0000, 5'd31, w);
      send(1'b1, 32'h7FFF_FFFF, 5'd31, w);
      drain("R5 drained");
   endtask

   task automatic t_latency();
      int w;
      cur_tag = "R6";
      send(1'b0, 32'h0000_00F0, 5'd3, w);
      idle();
      for (int k = 1; k <= 6; k++) begin
         #4;
         check(out_valid == (k == 6), "R6 latency", 32'(out_valid), 32'(k == 6));
         @(negedge clk);
      end
      drain("R6 drained");
   endtask

   task automatic t_stream();
      int w;
      int base;
      int stalls = 0;
      cur_tag = "R7";
      base = n_out;
      for (int i = 0; i < 20; i++) begin
         send(i[0], 32'h9E37_79B9 * (i + 1), 5'(i * 7), w);
         stalls += w;
      end
      idle();
      check(stalls == 0, "R7 input stalls", 32'(stalls), 32'd0);
      repeat (7) @(negedge clk);
      check(n_out - base == 20, "R7 results delivered", 32'(n_out - base), 32'd20);
      drain("R7 drained");
   endtask

   task automatic t_backpressure();
      int w;
      logic [31:0] held;
      cur_tag = "R9";
      out_ready = 1'b0;
      for (int i = 0; i < 6; i++) send(1'b1, 32'hF000_0000 + i, 5'(i + 2), w);
      idle();
      held = ref_shift(1'b1, 32'hF000_0000, 5'd2);
      repeat (3) begin
         #4;
         check(in_ready == 1'b0, "R9 in_ready low when full", 32'(in_ready), 32'd0);
         check(out_valid && out_data == held, "R9 output held", out_data, held);
         @(negedge clk);
      end
      in_valid = 1'b1;
      in_mode  = 1'b0;
      in_data  = 32'h0000_FFFF;
      in_shamt = 5'd4;
      #4;
      check(in_ready == 1'b0, "R9 extra request refused", 32'(in_ready), 32'd0);
      @(negedge clk);
      out_ready = 1'b1;
      send(1'b0, 32'h0000_FFFF, 5'd4, w);
      drain("R9 drained");
   endtask

   task automatic t_random_stall();
      int base;
      int sent = 0;
      bit done = 1'b0;
      logic [15:0] lfsr = 16'hACE1;
      cur_tag = "R10";
      base = n_out;
      fork
         begin
            int w;
            for (int i = 0; i < 40; i++) begin
               send(i[1], 32'h0BAD_F00D ^ (32'(i) << 11) ^ 32'(i * 3), 5'(i * 5 + 1), w);
               sent++;
               if (i % 5 == 4) begin
                  idle();
                  @(negedge clk);
               end
            end
            idle();
            done = 1'b1;
         end
         begin
            while (!done) begin
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               out_ready = lfsr[0] | lfsr[3];
               @(negedge clk);
            end
         end
      join
      drain("R8 queue empty");
      check(n_out - base == sent, "R10 one result per request", 32'(n_out - base), 32'(sent));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_logical();
      t_arith();
      t_zero();
      t_max();
      t_latency();
      t_stream();
      t_backpressure();
      t_random_stall();
      repeat (2) @(negedge clk);
      finish_up();
   end

endmodule